// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that moves data by following a chain of descriptors stored in memory. Each descriptor is four 32-bit words. The channel reads the descriptor at the address held in its pointer register and copies the number of bytes the descriptor gives from a source address to a target address. It then moves to the next descriptor in the chain. A flag in the link word can halt the chain, and a link that points back to an earlier descriptor makes the channel run without end.

Software uses four word registers. It loads the pointer, sets the run bit, and then watches the status flags or the interrupt line. While the channel runs, software can read the live source and target addresses to work out how far the transfer has got.

The memory master port has one outstanding access at a time. It carries a byte count of 1 to 4, and data travels on the low byte lanes. When flow control is selected, the peripheral request input paces each burst.

Top module: `dchn_engine`

## Requirements
- R1: After reset, the control word (register 0) reads 0x0000_0008: run clear and stopped set. `irq` is low and `mem_req` is low.
- R2: Setting the run bit (control bit 31) while stopped starts the fetch. The channel reads four words at pointer+0, +4, +8 and +12 as link, source, target and command. It then moves the data one element at a time, a read from the source followed by a write to the target. `mem_req`, `mem_addr` and `mem_we` stay steady until `mem_ack`.
- R3: Command bit 31 steps the source address and bit 30 steps the target address, each by the element size. When a bit is clear, that address stays fixed.
- R4: Command bits 15:14 give the element width: 1 means 1 byte, 2 means 2 bytes, and 0 or 3 mean 4 bytes. Bits 12:0 give the byte length. Each element moves min(width, bytes left) bytes. A length of 0 moves nothing and completes the descriptor.
- R5: If link bit 0 is set, the channel stops once the descriptor completes. The run bit then reads 0, the stopped bit (bit 3) reads 1, and the pointer register reads the link with its low 4 bits cleared.
- R6: If link bit 0 is clear, the channel goes on to fetch the descriptor at the link address with its low 4 bits cleared.
- R7: A descriptor with command bit 21 sets the end flag (control bit 2) when it completes. A descriptor with command bit 22 sets the start flag (bit 1) when it is loaded. `irq` is the OR of the end, start and bus-error flags. Writing a 1 to a flag bit clears it.
- R8: If command bit 29 or bit 28 is set, a burst starts only while `dreq` is high. A burst is 1 element for code 0 in command bits 17:16, and 8, 16 or 32 bytes for codes 1, 2 and 3. With both bits clear, `dreq` has no effect.
- R9: If the run bit is cleared during a burst, that burst finishes. The channel then stops without starting another burst.
- R10: A `mem_err` returned with `mem_ack` sets the bus-error flag (bit 0) and clears run. The channel stops with no further memory requests.
- R11: A chain whose last link points back to its first descriptor keeps running. The end flag is set again after each pass through a descriptor that has command bit 21.
- R12: Writes to the pointer register (register 1) are ignored while the channel is not stopped.
- R13: Registers 2 and 3 return the live source and target addresses at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 pointer, 2 source, 3 target |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_len | output | 3 | Byte count of the access, 1 to 4 |
| mem_wdata | output | 32 | Write data, low lanes |
| mem_rdata | input | 32 | Read data, low lanes, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| dreq | input | 1 | Peripheral request for flow-controlled bursts |
| irq | output | 1 | Interrupt, OR of the status flags |

## Verification
The assertions check four things on every cycle:
- a pending memory request holds its address until it is acknowledged;
- each write carries a byte count no larger than the bytes left;
- an error response, or a stop flag, leaves the channel halted with run clear;
- the pointer does not move during a fetch or a transfer.

Only the bench's scenarios can show that the addresses and data of every write follow the descriptor chain. The same is true for partial last elements, fixed addresses, pacing by `dreq`, a burst finishing after run is cleared, and a cyclic chain raising its end flag again and again.

// File: rtl/dchn_pkg.sv
package dchn_pkg;
    localparam int LEN_W = 13;
    localparam int BUD_W = 6;

    localparam int CMD_INC_SRC = 31;
    localparam int CMD_INC_DST = 30;
    localparam int CMD_FLOW_S  = 29;
    localparam int CMD_FLOW_T  = 28;
    localparam int CMD_IRQ_BEG = 22;
    localparam int CMD_IRQ_END = 21;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_DONE
    } dchn_st_e;

    typedef struct packed {
        dchn_st_e           st;
        logic               run;
        logic               f_end;
        logic               f_beg;
        logic               f_err;
        logic [1:0]         widx;
        logic [31:0]        ptr;
        logic [31:0]        link;
        logic [31:0]        src;
        logic [31:0]        dst;
        logic [31:0]        cmd;
        logic [31:0]        data;
        logic [LEN_W-1:0]   rem;
        logic [BUD_W-1:0]   budget;
    } dchn_state_t;
endpackage

// File: rtl/dchn_elem_calc.sv
module dchn_elem_calc
    import dchn_pkg::*;
(
    input  logic [31:0]       cmd,
    input  logic [LEN_W-1:0]  rem,
    input  logic [BUD_W-1:0]  budget,
    output logic [2:0]        step,
    output logic [BUD_W-1:0]  burst_init,
    output logic [BUD_W-1:0]  budget_after,
    output logic [LEN_W-1:0]  rem_after
);
    logic [2:0] wbytes;

    always_comb begin
        case (cmd[15:14])
            2'd1:    wbytes = 3'd1;
            2'd2:    wbytes = 3'd2;
            default: wbytes = 3'd4;
        endcase
        if (rem < {{(LEN_W-3){1'b0}}, wbytes}) step = rem[2:0];
        else                                   step = wbytes;
        case (cmd[17:16])
            2'd1:    burst_init = BUD_W'(8);
            2'd2:    burst_init = BUD_W'(16);
            2'd3:    burst_init = BUD_W'(32);
            default: burst_init = BUD_W'(1);
        endcase
        if (budget > {{(BUD_W-3){1'b0}}, step})
            budget_after = budget - {{(BUD_W-3){1'b0}}, step};
        else
            budget_after = '0;
        rem_after = rem - {{(LEN_W-3){1'b0}}, step};
    end
endmodule

// File: rtl/dchn_reg_mux.sv
module dchn_reg_mux (
    input  logic [1:0]  sel,
    input  logic        run,
    input  logic        stopped,
    input  logic        f_end,
    input  logic        f_beg,
    input  logic        f_err,
    input  logic [31:0] ptr,
    input  logic [31:0] src,
    input  logic [31:0] dst,
    output logic [31:0] rdata
);
    always_comb begin
        case (sel)
            2'd0:    rdata = {run, 27'd0, stopped, f_end, f_beg, f_err};
            2'd1:    rdata = ptr;
            2'd2:    rdata = src;
            default: rdata = dst;
        endcase
    end
endmodule

// File: rtl/dchn_engine.sv
module dchn_engine
    import dchn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [2:0]  mem_len,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic        dreq,
    output logic        irq
);
    dchn_state_t s_q, s_d;

    logic [2:0]       step;
    logic [BUD_W-1:0] burst_init, budget_after;
    logic [LEN_W-1:0] rem_after;
    logic             flow;

    dchn_elem_calc u_calc (
        .cmd          (s_q.cmd),
        .rem          (s_q.rem),
        .budget       (s_q.budget),
        .step         (step),
        .burst_init   (burst_init),
        .budget_after (budget_after),
        .rem_after    (rem_after)
    );

    dchn_reg_mux u_mux (
        .sel     (reg_addr),
        .run     (s_q.run),
        .stopped (s_q.st == S_IDLE),
        .f_end   (s_q.f_end),
        .f_beg   (s_q.f_beg),
        .f_err   (s_q.f_err),
        .ptr     (s_q.ptr),
        .src     (s_q.src),
        .dst     (s_q.dst),
        .rdata   (reg_rdata)
    );

    assign flow = s_q.cmd[CMD_FLOW_S] | s_q.cmd[CMD_FLOW_T];
    assign irq  = s_q.f_end | s_q.f_beg | s_q.f_err;

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_len   = 3'd4;
        mem_wdata = s_q.data;

        if (reg_wr && reg_addr == 2'd0) begin
            s_d.run = reg_wdata[31];
            if (reg_wdata[2]) s_d.f_end = 1'b0;
            if (reg_wdata[1]) s_d.f_beg = 1'b0;
            if (reg_wdata[0]) s_d.f_err = 1'b0;
        end
        if (reg_wr && reg_addr == 2'd1 && s_q.st == S_IDLE)
            s_d.ptr = reg_wdata;

        case (s_q.st)
            S_IDLE: begin
                if (s_q.run) begin
                    s_d.st   = S_FETCH;
                    s_d.widx = 2'd0;
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = s_q.ptr + {28'd0, s_q.widx, 2'b00};
                if (mem_ack && !mem_err) begin
                    s_d.widx = s_q.widx + 2'd1;
                    case (s_q.widx)
                        2'd0: s_d.link = mem_rdata;
                        2'd1: s_d.src  = mem_rdata;
                        2'd2: s_d.dst  = mem_rdata;
                        default: begin
                            s_d.cmd = mem_rdata;
                            s_d.rem = mem_rdata[LEN_W-1:0];
                            if (mem_rdata[CMD_IRQ_BEG]) s_d.f_beg = 1'b1;
                            s_d.st  = S_CHECK;
                        end
                    endcase
                end
            end
            S_CHECK: begin
                if (!s_d.run)                s_d.st = S_IDLE;
                else if (s_q.rem == '0)      s_d.st = S_DONE;
                else if (!flow || dreq) begin
                    s_d.budget = burst_init;
                    s_d.st     = S_RD;
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = s_q.src;
                mem_len  = step;
                if (mem_ack && !mem_err) begin
                    s_d.data = mem_rdata;
                    s_d.st   = S_WR;
                end
            end
            S_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_q.dst;
                mem_len  = step;
                if (mem_ack && !mem_err) begin
                    if (s_q.cmd[CMD_INC_SRC]) s_d.src = s_q.src + {29'd0, step};
                    if (s_q.cmd[CMD_INC_DST]) s_d.dst = s_q.dst + {29'd0, step};
                    s_d.rem    = rem_after;
                    s_d.budget = budget_after;
                    if (rem_after == '0)          s_d.st = S_DONE;
                    else if (budget_after == '0)  s_d.st = S_CHECK;
                    else                          s_d.st = S_RD;
                end
            end
            S_DONE: begin
                if (s_q.cmd[CMD_IRQ_END]) s_d.f_end = 1'b1;
                s_d.ptr = {s_q.link[31:4], 4'h0};
                if (s_q.link[0]) begin
                    s_d.run = 1'b0;
                    s_d.st  = S_IDLE;
                end else if (!s_d.run) begin
                    s_d.st  = S_IDLE;
                end else begin
                    s_d.st   = S_FETCH;
                    s_d.widx = 2'd0;
                end
            end
            default: s_d.st = S_IDLE;
        endcase

        if (mem_req && mem_ack && mem_err) begin
            s_d.f_err = 1'b1;
            s_d.run   = 1'b0;
            s_d.st    = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a request stays put until the memory acknowledges it
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: a write never carries more bytes than remain
    p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_len != 3'd0 && {10'd0, mem_len} <= s_q.rem));

    // R10: an error response halts the channel with the flag set
    p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (s_q.st == S_IDLE && s_q.f_err && !s_q.run));

    // R5: a stop flag in the link ends the chain
    p_stop_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_DONE && s_q.link[0]) |=> (s_q.st == S_IDLE && !s_q.run));

    // R7: an end request raises the end flag
    p_end_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_DONE && s_q.cmd[CMD_IRQ_END]) |=> s_q.f_end);

    // R12: the pointer is frozen while a descriptor is in use
    p_ptr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st inside {S_FETCH, S_CHECK, S_RD, S_WR}) |=> (s_q.ptr == $past(s_q.ptr)));
endmodule

// File: tb/dchn_engine_tb.sv
module dchn_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [2:0]  mem_len;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        dreq = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_writes = 0;
    int n_reqs = 0;
    bit err_en = 1'b0;
    logic [31:0] err_addr = '0;
    string cur_req = "R2";

    logic [7:0]  mem [int unsigned];
    logic [31:0] exp_a[$];
    int          exp_l[$];
    logic [31:0] exp_d[$];

    always #10 clk = ~clk;

    dchn_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .dreq(dreq), .irq(irq)
    );

    function automatic logic [31:0] rd_bytes(input logic [31:0] a, input int len);
        logic [31:0] v = '0;
        for (int i = 0; i < len; i++)
            v[8*i +: 8] = mem.exists(a + i) ? mem[a + i] : 8'h00;
        return v;
    endfunction

    task automatic wr_bytes(input logic [31:0] a, input logic [31:0] v, input int len);
        for (int i = 0; i < len; i++) mem[a + i] = v[8*i +: 8];
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input int len);
        return (len >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*len)) - 32'h1);
    endfunction

    // behavioural memory: acknowledges one cycle after a request, compares writes
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (rst_n && mem_req) begin
            n_reqs++;
            mem_ack = 1'b1;
            mem_err = err_en && (mem_addr == err_addr);
            if (!mem_we) begin
                mem_rdata = rd_bytes(mem_addr, int'(mem_len));
            end else if (!mem_err) begin
                n_writes++;
                wr_bytes(mem_addr, mem_wdata, int'(mem_len));
                if (exp_a.size() == 0) begin
                    chk({cur_req, " unexpected write"}, mem_addr, 32'hFFFF_FFFF);
                end else begin
                    chk({cur_req, " write addr"}, mem_addr, exp_a[0]);
                    chk({cur_req, " write len"}, {29'd0, mem_len}, exp_l[0]);
                    chk({cur_req, " write data"}, mem_wdata & lane_mask(exp_l[0]),
                        exp_d[0] & lane_mask(exp_l[0]));
                    void'(exp_a.pop_front());
                    void'(exp_l.pop_front());
                    void'(exp_d.pop_front());
                end
            end
        end
    end

    task automatic put_desc(input logic [31:0] at, input logic [31:0] lk,
                            input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        wr_bytes(at, lk, 4);
        wr_bytes(at + 4, s, 4);
        wr_bytes(at + 8, d, 4);
        wr_bytes(at + 12, c, 4);
    endtask

    // reference walk of the chain, built from the requirements
    task automatic build_exp(input logic [31:0] head, input int ndesc, input int maxw);
        logic [31:0] p = head;
        int pushed = 0;
        for (int k = 0; k < ndesc; k++) begin
            logic [31:0] lk = rd_bytes(p, 4);
            logic [31:0] s  = rd_bytes(p + 4, 4);
            logic [31:0] d  = rd_bytes(p + 8, 4);
            logic [31:0] c  = rd_bytes(p + 12, 4);
            int rem = int'(c[12:0]);
            int w = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
            while (rem > 0 && pushed < maxw) begin
                int st = (rem < w) ? rem : w;
                exp_a.push_back(d);
                exp_l.push_back(st);
                exp_d.push_back(rd_bytes(s, st));
                pushed++;
                if (c[31]) s = s + st;
                if (c[30]) d = d + st;
                rem = rem - st;
            end
            if (lk[0]) break;
            p = {lk[31:4], 4'h0};
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            rd_reg(2'd0, v);
            if (v[3]) break;
        end
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 512; i++) mem[32'h2000 + i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, v);
        chk("R1 ctrl", v, 32'h0000_0008);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // R2 R3 R4 R6 chained memory copy, dreq low (R8 no pacing)
        cur_req = "R2";
        put_desc(32'h1000, 32'h1020, 32'h2000, 32'h3000,
                 32'hC000_0000 | (1 << 22) | (3 << 16) | (3 << 14) | 10);
        put_desc(32'h1020, 32'h1041, 32'h2100, 32'h3100,
                 32'h8000_0000 | (1 << 21) | (3 << 16) | (1 << 14) | 3);
        build_exp(32'h1000, 4, 1000);
        n_writes = 0;
        wr_reg(2'd1, 32'h1000);
        wr_reg(2'd0, 32'h8000_0000);
        wait_stop();
        chk("R6 all chained writes seen", exp_a.size(), 0);
        chk("R8 memory copy ignores dreq", n_writes, 6);
        rd_reg(2'd0, v);
        chk("R5 R7 ctrl after stop", v, 32'h0000_000E);
        rd_reg(2'd1, v);
        chk("R5 pointer holds link", v, 32'h0000_1040);
        rd_reg(2'd2, v);
        chk("R3 R13 source stepped", v, 32'h0000_2103);
        rd_reg(2'd3, v);
        chk("R3 R13 target fixed", v, 32'h0000_3100);
        chk("R7 irq raised", {31'd0, irq}, 32'd1);
        wr_reg(2'd0, 32'h0000_0006);
        rd_reg(2'd0, v);
        chk("R7 flags cleared by write-one", v, 32'h0000_0008);
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);

        // R4 zero-length descriptor
        cur_req = "R4";
        put_desc(32'h1080, 32'h1091, 32'h2000, 32'h3500, 32'hC000_0000 | (1 << 21));
        n_writes = 0;
        wr_reg(2'd1, 32'h1080);
        wr_reg(2'd0, 32'h8000_0000);
        wait_stop();
        chk("R4 zero length moves nothing", n_writes, 0);
        rd_reg(2'd0, v);
        chk("R4 zero length completes", v, 32'h0000_000C);
        wr_reg(2'd0, 32'h0000_0007);

        // R8 R9 R12 paced transfer, run cleared mid-burst
        cur_req = "R9";
        put_desc(32'h1100, 32'h1141, 32'h2000, 32'h3200,
                 32'hC000_0000 | (1 << 28) | (2 << 16) | (3 << 14) | 64);
        build_exp(32'h1100, 1, 4);
        n_writes = 0;
        dreq = 1'b0;
        wr_reg(2'd1, 32'h1100);
        wr_reg(2'd0, 32'h8000_0000);
        repeat (30) @(negedge clk);
        chk("R8 no transfer without dreq", n_writes, 0);
        rd_reg(2'd2, v);
        chk("R13 live source before burst", v, 32'h0000_2000);
        wr_reg(2'd1, 32'h0000_5550);
        rd_reg(2'd1, v);
        chk("R12 pointer write ignored while running", v, 32'h0000_1100);
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        dreq = 1'b0;
        wr_reg(2'd0, 32'h0000_0000);
        wait_stop();
        chk("R9 burst finished then stopped", n_writes, 4);
        chk("R9 expected burst writes seen", exp_a.size(), 0);
        rd_reg(2'd3, v);
        chk("R13 live target after burst", v, 32'h0000_3210);
        rd_reg(2'd0, v);
        chk("R9 run clear and stopped", v, 32'h0000_0008);

        // R10 bus error on the second source read
        cur_req = "R10";
        put_desc(32'h1200, 32'h1241, 32'h2000, 32'h3300,
                 32'hC000_0000 | (3 << 16) | (3 << 14) | 12);
        build_exp(32'h1200, 1, 1);
        err_en = 1'b1;
        err_addr = 32'h2004;
        n_writes = 0;
        wr_reg(2'd1, 32'h1200);
        wr_reg(2'd0, 32'h8000_0000);
        wait_stop();
        rd_reg(2'd0, v);
        chk("R10 error flag and stop", v, 32'h0000_0009);
        chk("R10 irq", {31'd0, irq}, 32'd1);
        chk("R10 writes before error", n_writes, 1);
        n_reqs = 0;
        repeat (10) @(negedge clk);
        chk("R10 no requests after error", n_reqs, 0);
        err_en = 1'b0;
        wr_reg(2'd0, 32'h0000_0001);
        rd_reg(2'd0, v);
        chk("R10 error flag cleared", v, 32'h0000_0008);

        // R11 cyclic chain
        cur_req = "R11";
        put_desc(32'h1300, 32'h1320, 32'h2000, 32'h3400,
                 32'hC000_0000 | (3 << 16) | (3 << 14) | 8);
        put_desc(32'h1320, 32'h1300, 32'h2040, 32'h3440,
                 32'hC000_0000 | (1 << 21) | (3 << 16) | (3 << 14) | 8);
        build_exp(32'h1300, 40, 80);
        n_writes = 0;
        wr_reg(2'd1, 32'h1300);
        wr_reg(2'd0, 32'h8000_0000);
        for (int i = 0; i < 5000 && n_writes < 12; i++) @(negedge clk);
        rd_reg(2'd0, v);
        chk("R11 end flag after loops", {31'd0, v[2]}, 32'd1);
        chk("R11 still running", {31'd0, v[31]}, 32'd1);
        wr_reg(2'd0, 32'h8000_0004);
        for (int i = 0; i < 5000 && n_writes < 24; i++) @(negedge clk);
        rd_reg(2'd0, v);
        chk("R11 end flag raised again", {31'd0, v[2]}, 32'd1);
        wr_reg(2'd0, 32'h0000_0000);
        wait_stop();
        rd_reg(2'd0, v);
        chk("R11 stopped after run clear", {31'd0, v[31], v[3]}, 32'd1);
        exp_a.delete();
        exp_l.delete();
        exp_d.delete();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule